// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs the interrupt entry and return sequences of a small 8-bit processor core. The core has a 16-bit address space and an 8-bit data path. The block watches four sources: a reset request, an edge-triggered non-maskable input, a level-sensitive maskable input, and a software break request from the core.

When the block accepts an entry, it pushes three bytes onto a descending stack in page one: the return address (high byte first) and then the status byte. It then reads a two-byte handler address from a fixed vector near the top of memory. When the core asks for a return, the block pulls the status byte, the low return byte and the high return byte, in that order, starting just above the current stack pointer.

The core gives the block its next-instruction address, its stack pointer and its status byte. While `busy` is high the core stalls its instruction fetch. In the single cycle where `done` is high, the core loads the new program counter, stack pointer and status from the block. Memory is a single synchronous port: read data is valid in the cycle after the address is presented.

Top module: `irq_seq`

## Requirements
- R1: After `rst` is released, the block runs a reset sequence without asserting `mem_wr`. It reads the low vector byte at 0xFFFC and the high byte at 0xFFFD. On `done` it returns `sp_out` = 0xFD and `p_out` with bit 2 (interrupt disable) set. While `rst` is high, `busy`, `done` and `mem_wr` are 0.
- R2: The vector addresses are 0xFFFA/0xFFFB for the non-maskable source and 0xFFFE/0xFFFF for both the maskable source and the software break. The first cycle of entry after the pushes presents the low address and the next cycle presents the high address. `pc_out` equals high*256 + low.
- R3: An entry writes `pc_in[15:8]` to 0x0100+SP, then `pc_in[7:0]` to 0x0100+SP-1, then the status byte to 0x0100+SP-2, in three consecutive cycles. SP wraps in 8 bits, and `sp_out` equals SP-3.
- R4: An entry keeps `busy` high for exactly 7 cycles. The 3 write cycles come first, `done` is high in the 7th cycle, and `pc_out`, `sp_out` and `p_out` are valid in that cycle.
- R5: The pushed status byte has bit 4 (break) set for a software break and cleared for a hardware source. All other bits are copied from `p_in`. `p_out` after an entry is `p_in` with bit 2 set.
- R6: The maskable input is ignored while `p_in` bit 2 is set: no sequence starts and nothing is written.
- R7: A rising edge on `nmi_in` is latched until serviced. Bit 2 does not block it. Holding `nmi_in` high does not start a second sequence.
- R8: When sources compete at an accepting cycle, the order is a latched non-maskable request first, then the maskable input, then the break request, then the return request.
- R9: A return reads 0x0100+SP+1 (status), then +2 (low byte), then +3 (high byte), never writes, and keeps `busy` high for exactly 6 cycles with `done` in the 6th. `p_out` equals the pulled status byte in every bit, `pc_out` equals high*256 + low, and `sp_out` equals SP+3 wrapped in 8 bits.
- R10: `done` lasts one cycle. `mem_wr` is only ever asserted for addresses in page one, and consecutive writes go to descending addresses.
- R11: The maskable, break and return requests are accepted only while the block is idle and `boundary` is high. Otherwise they have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; schedules the reset sequence |
| nmi_in | input | 1 | Non-maskable request, rising-edge sensitive |
| irq_in | input | 1 | Maskable request, level sensitive |
| brk_req | input | 1 | Software break request from the core |
| rti_req | input | 1 | Return-from-interrupt request from the core |
| boundary | input | 1 | Core is at an instruction boundary |
| pc_in | input | 16 | Address of the next instruction |
| sp_in | input | 8 | Current stack pointer |
| p_in | input | 8 | Current status byte |
| mem_addr | output | 16 | Memory address |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after the address |
| pc_out | output | 16 | New program counter, valid with `done` |
| sp_out | output | 8 | New stack pointer, valid with `done` |
| p_out | output | 8 | New status byte, valid with `done` |
| busy | output | 1 | Sequence in progress; the core stalls its fetch |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 16-bit address, the stack in page one, a reset stack value of 0xFD, and the standard vector addresses. The 8-bit stack pointer lets a push starting at SP = 0x01 and a pull starting at SP = 0xFE cross the 0x00/0xFF wrap within a single sequence. The bench therefore checks wrap-around in both directions and a full push/pull round trip of the same bytes. A behavioural memory and a per-cycle expectation of strobe, address, data and completion are compared in every cycle of every sequence.

// File: rtl/irq_seq_pkg.sv
`timescale 1ns/1ps
package irq_seq_pkg;
  typedef enum logic [2:0] {K_RST, K_NMI, K_IRQ, K_BRK, K_RTI} src_e;

  typedef enum logic [3:0] {
    S_IDLE,
    E_PUSH_HI, E_PUSH_LO, E_PUSH_ST, E_VEC_LO, E_VEC_HI, E_VEC_WAIT, E_DONE,
    R_INC, R_PULL_ST, R_PULL_LO, R_PULL_HI, R_WAIT, R_DONE
  } seq_e;

  localparam int BIT_IDIS = 2;
  localparam int BIT_BRK  = 4;
endpackage

// File: rtl/irq_seq_arb.sv
`timescale 1ns/1ps
module irq_seq_arb
  import irq_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic nmi_in,
  input  logic irq_in,
  input  logic brk_req,
  input  logic rti_req,
  input  logic boundary,
  input  logic idis,
  input  logic idle,
  output logic go,
  output src_e src
);
  logic nmi_q, nmi_pend, rst_pend;
  logic nmi_rise;

  assign nmi_rise = nmi_in & ~nmi_q;

  always_comb begin
    go  = 1'b0;
    src = K_RST;
    if (idle) begin
      if (rst_pend) begin
        go = 1'b1;
      end else if (boundary) begin
        if (nmi_pend) begin
          go = 1'b1; src = K_NMI;
        end else if (irq_in && !idis) begin
          go = 1'b1; src = K_IRQ;
        end else if (brk_req) begin
          go = 1'b1; src = K_BRK;
        end else if (rti_req) begin
          go = 1'b1; src = K_RTI;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
      rst_pend <= 1'b1;
    end else begin
      nmi_q    <= nmi_in;
      rst_pend <= rst_pend & ~go;
      nmi_pend <= (nmi_pend & ~(go && src == K_NMI)) | nmi_rise;
    end
  end
endmodule

// File: rtl/irq_seq_ctrl.sv
`timescale 1ns/1ps
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2 * DW,
  parameter logic [DW-1:0] STACK_PAGE = 8'h01,
  parameter logic [DW-1:0] SP_INIT    = 8'hFD,
  parameter logic [AW-1:0] VEC_NMI    = 16'hFFFA,
  parameter logic [AW-1:0] VEC_RST    = 16'hFFFC,
  parameter logic [AW-1:0] VEC_IRQ    = 16'hFFFE
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  src_e          src,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] sp_in,
  input  logic [DW-1:0] p_in,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] pc_out,
  output logic [DW-1:0] sp_out,
  output logic [DW-1:0] p_out,
  output logic          busy,
  output logic          done,
  output logic          idle
);
  localparam logic [DW-1:0] IDIS_M = DW'(1) << BIT_IDIS;
  localparam logic [DW-1:0] BRK_M  = DW'(1) << BIT_BRK;

  seq_e          st;
  src_e          kind;
  logic [AW-1:0] pc_sav, pc_r;
  logic [DW-1:0] sp_r, p_sav, p_r, lo_r;
  logic [AW-1:0] stk_addr, vec_base;
  logic [DW-1:0] pushed_st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      kind   <= K_RST;
      pc_sav <= '0;
      pc_r   <= '0;
      sp_r   <= '0;
      p_sav  <= '0;
      p_r    <= '0;
      lo_r   <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          pc_sav <= pc_in;
          sp_r   <= sp_in;
          p_sav  <= p_in;
          kind   <= src;
          st     <= (src == K_RTI) ? R_INC : E_PUSH_HI;
        end
        E_PUSH_HI: begin sp_r <= sp_r - DW'(1); st <= E_PUSH_LO; end
        E_PUSH_LO: begin sp_r <= sp_r - DW'(1); st <= E_PUSH_ST; end
        E_PUSH_ST: begin sp_r <= sp_r - DW'(1); st <= E_VEC_LO;  end
        E_VEC_LO:  st <= E_VEC_HI;
        E_VEC_HI:  begin lo_r <= mem_rdata; st <= E_VEC_WAIT; end
        E_VEC_WAIT: begin
          pc_r <= {mem_rdata, lo_r};
          p_r  <= p_sav | IDIS_M;
          if (kind == K_RST) sp_r <= SP_INIT;
          st   <= E_DONE;
        end
        E_DONE:    st <= S_IDLE;
        R_INC:     begin sp_r <= sp_r + DW'(1); st <= R_PULL_ST; end
        R_PULL_ST: begin sp_r <= sp_r + DW'(1); st <= R_PULL_LO; end
        R_PULL_LO: begin p_r <= mem_rdata; sp_r <= sp_r + DW'(1); st <= R_PULL_HI; end
        R_PULL_HI: begin lo_r <= mem_rdata; st <= R_WAIT; end
        R_WAIT:    begin pc_r <= {mem_rdata, lo_r}; st <= R_DONE; end
        R_DONE:    st <= S_IDLE;
        default:   st <= S_IDLE;
      endcase
    end
  end

  assign stk_addr = {STACK_PAGE, sp_r};

  always_comb begin
    case (kind)
      K_NMI:   vec_base = VEC_NMI;
      K_RST:   vec_base = VEC_RST;
      default: vec_base = VEC_IRQ;
    endcase
  end

  assign pushed_st = (kind == K_BRK) ? (p_sav | BRK_M) : (p_sav & ~BRK_M);

  always_comb begin
    mem_addr  = '0;
    mem_wr    = 1'b0;
    mem_wdata = '0;
    case (st)
      E_PUSH_HI: begin
        mem_addr = stk_addr; mem_wr = (kind != K_RST); mem_wdata = pc_sav[AW-1:DW];
      end
      E_PUSH_LO: begin
        mem_addr = stk_addr; mem_wr = (kind != K_RST); mem_wdata = pc_sav[DW-1:0];
      end
      E_PUSH_ST: begin
        mem_addr = stk_addr; mem_wr = (kind != K_RST); mem_wdata = pushed_st;
      end
      E_VEC_LO:  mem_addr = vec_base;
      E_VEC_HI:  mem_addr = vec_base | AW'(1);
      R_PULL_ST, R_PULL_LO, R_PULL_HI: mem_addr = stk_addr;
      default: ;
    endcase
  end

  assign pc_out = pc_r;
  assign sp_out = sp_r;
  assign p_out  = p_r;
  assign idle   = (st == S_IDLE);
  assign busy   = (st != S_IDLE);
  assign done   = (st == E_DONE) || (st == R_DONE);
endmodule

// File: rtl/irq_seq.sv
`timescale 1ns/1ps
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2 * DW,
  parameter logic [DW-1:0] STACK_PAGE = 8'h01,
  parameter logic [DW-1:0] SP_INIT    = 8'hFD,
  parameter logic [AW-1:0] VEC_NMI    = 16'hFFFA,
  parameter logic [AW-1:0] VEC_RST    = 16'hFFFC,
  parameter logic [AW-1:0] VEC_IRQ    = 16'hFFFE
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          nmi_in,
  input  logic          irq_in,
  input  logic          brk_req,
  input  logic          rti_req,
  input  logic          boundary,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] sp_in,
  input  logic [DW-1:0] p_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] pc_out,
  output logic [DW-1:0] sp_out,
  output logic [DW-1:0] p_out,
  output logic          busy,
  output logic          done
);
  logic go, idle;
  src_e src;

  irq_seq_arb u_arb (
    .clk(clk), .rst(rst), .nmi_in(nmi_in), .irq_in(irq_in),
    .brk_req(brk_req), .rti_req(rti_req), .boundary(boundary),
    .idis(p_in[BIT_IDIS]), .idle(idle), .go(go), .src(src)
  );

  irq_seq_ctrl #(
    .DW(DW), .AW(AW), .STACK_PAGE(STACK_PAGE), .SP_INIT(SP_INIT),
    .VEC_NMI(VEC_NMI), .VEC_RST(VEC_RST), .VEC_IRQ(VEC_IRQ)
  ) u_ctrl (
    .clk(clk), .rst(rst), .go(go), .src(src),
    .pc_in(pc_in), .sp_in(sp_in), .p_in(p_in), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .pc_out(pc_out), .sp_out(sp_out), .p_out(p_out),
    .busy(busy), .done(done), .idle(idle)
  );
endmodule

// File: rtl/irq_seq_chk.sv
`timescale 1ns/1ps
module irq_seq_chk #(
  parameter int DW = 8,
  parameter int AW = 2 * DW,
  parameter logic [DW-1:0] STACK_PAGE = 8'h01
)(
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr
);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_stack_page_R10: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> mem_addr[AW-1:DW] == STACK_PAGE);

  assert_descend_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && $past(mem_wr)) |-> mem_addr[DW-1:0] == $past(mem_addr[DW-1:0]) - DW'(1));

  assert_three_pushes_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && $past(mem_wr) && $past(mem_wr, 2)) |=> !mem_wr);

  assert_busy_held_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);

  assert_done_in_busy_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
endmodule

bind irq_seq irq_seq_chk #(.DW(DW), .AW(AW), .STACK_PAGE(STACK_PAGE)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .mem_wr(mem_wr), .mem_addr(mem_addr)
);

// File: tb/irq_seq_tb.sv
`timescale 1ns/1ps
module irq_seq_tb;
  logic        clk = 1'b0;
  logic        rst, nmi_in, irq_in, brk_req, rti_req, boundary;
  logic [15:0] pc_in, mem_addr, pc_out;
  logic [7:0]  sp_in, p_in, mem_wdata, mem_rdata, sp_out, p_out;
  logic        mem_wr, busy, done;
  int checks = 0;
  int errors = 0;
  logic [7:0] stk [256];

  always #2.5 clk = ~clk;

  irq_seq u_dut (
    .clk(clk), .rst(rst), .nmi_in(nmi_in), .irq_in(irq_in), .brk_req(brk_req),
    .rti_req(rti_req), .boundary(boundary), .pc_in(pc_in), .sp_in(sp_in), .p_in(p_in),
    .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pc_out(pc_out), .sp_out(sp_out), .p_out(p_out), .busy(busy), .done(done)
  );

  function automatic logic [7:0] rd(input logic [15:0] a);
    if (a[15:8] == 8'h01) return stk[a[7:0]];
    case (a)
      16'hFFFA: return 8'h34;
      16'hFFFB: return 8'h12;
      16'hFFFC: return 8'h00;
      16'hFFFD: return 8'h80;
      16'hFFFE: return 8'hCD;
      16'hFFFF: return 8'hAB;
      default:  return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (mem_wr && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= rd(mem_addr);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  // Called in cycle 1 of an entry (one negedge after the accepting edge).
  task automatic expect_entry(input bit is_rst, input logic [15:0] pc, input logic [7:0] sp,
                              input logic [7:0] pst, input logic [15:0] vec,
                              input logic [15:0] exp_pc, input logic [7:0] exp_p, input string req);
    logic [7:0] exp_sp;
    exp_sp = is_rst ? 8'hFD : sp - 8'd3;
    for (int c = 1; c <= 7; c++) begin
      chk(busy == 1'b1, {req, " R4 busy"}, busy, 1);
      chk(done == (c == 7), {req, " R10 done"}, done, (c == 7));
      chk(mem_wr == (!is_rst && c <= 3), {req, " R10 write strobe"}, mem_wr, (!is_rst && c <= 3));
      if (!is_rst && c <= 3) begin
        chk(mem_addr == {8'h01, sp - 8'(c - 1)}, {req, " R3 push addr"}, mem_addr, {8'h01, sp - 8'(c - 1)});
        chk(mem_wdata == (c == 1 ? pc[15:8] : c == 2 ? pc[7:0] : pst),
            {req, " R3 R5 push data"}, mem_wdata, (c == 1 ? pc[15:8] : c == 2 ? pc[7:0] : pst));
      end
      if (c == 4) chk(mem_addr == vec, {req, " R2 vector low addr"}, mem_addr, vec);
      if (c == 5) chk(mem_addr == (vec | 16'h1), {req, " R2 vector high addr"}, mem_addr, vec | 16'h1);
      if (c == 7) begin
        chk(pc_out == exp_pc, {req, " R2 pc_out"}, pc_out, exp_pc);
        chk(sp_out == exp_sp, {req, " R3 sp_out"}, sp_out, exp_sp);
        chk(p_out == exp_p, {req, " R5 p_out"}, p_out, exp_p);
      end
      @(negedge clk);
    end
    chk(busy == 1'b0, {req, " R4 idle after entry"}, busy, 0);
  endtask

  task automatic expect_ret(input logic [7:0] sp, input logic [7:0] exp_p, input logic [15:0] exp_pc);
    for (int c = 1; c <= 6; c++) begin
      chk(busy == 1'b1, "R9 busy", busy, 1);
      chk(done == (c == 6), "R9 done", done, (c == 6));
      chk(mem_wr == 1'b0, "R9 no write", mem_wr, 0);
      if (c >= 2 && c <= 4)
        chk(mem_addr == {8'h01, sp + 8'(c - 1)}, "R9 pull addr", mem_addr, {8'h01, sp + 8'(c - 1)});
      if (c == 6) begin
        chk(pc_out == exp_pc, "R9 pc_out", pc_out, exp_pc);
        chk(sp_out == sp + 8'd3, "R9 sp_out", sp_out, sp + 8'd3);
        chk(p_out == exp_p, "R9 p_out", p_out, exp_p);
      end
      @(negedge clk);
    end
    chk(busy == 1'b0, "R9 idle after return", busy, 0);
  endtask

  task automatic expect_idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(busy == 1'b0 && mem_wr == 1'b0, req, {busy, mem_wr}, 0);
    end
  endtask

  // Present one request at a boundary for a single accepting edge.
  task automatic kick(input bit irq, input bit brk, input bit rti,
                      input logic [15:0] pc, input logic [7:0] sp, input logic [7:0] p);
    irq_in = irq; brk_req = brk; rti_req = rti; pc_in = pc; sp_in = sp; p_in = p; boundary = 1'b1;
    @(negedge clk);
    irq_in = 1'b0; brk_req = 1'b0; rti_req = 1'b0; boundary = 1'b0;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) stk[i] = 8'h00;
    rst = 1'b1; nmi_in = 1'b0; irq_in = 1'b0; brk_req = 1'b0; rti_req = 1'b0;
    boundary = 1'b0; pc_in = 16'h0; sp_in = 8'h0; p_in = 8'h00;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && mem_wr == 0, "R1 reset state", {busy, done, mem_wr}, 0);
    rst = 1'b0;
    @(negedge clk);
    expect_entry(1'b1, 16'h0, 8'h0, 8'h0, 16'hFFFC, 16'h8000, 8'h04, "R1 reset seq");

    // Maskable entry, incoming break bit cleared in pushed byte
    kick(1'b1, 1'b0, 1'b0, 16'h4567, 8'hFD, 8'h93);
    expect_entry(1'b0, 16'h4567, 8'hFD, 8'h83, 16'hFFFE, 16'hABCD, 8'h97, "R2 R5 irq");

    // R6: masked interrupt ignored
    irq_in = 1'b1; p_in = 8'h04; boundary = 1'b1;
    expect_idle(4, "R6 masked irq ignored");
    // R11: no boundary, no acceptance
    p_in = 8'h00; boundary = 1'b0; brk_req = 1'b1; rti_req = 1'b1;
    expect_idle(4, "R11 requests ignored without boundary");
    irq_in = 1'b0; brk_req = 1'b0; rti_req = 1'b0;

    // Software break, pushed with break bit set
    kick(1'b0, 1'b1, 1'b0, 16'h2000, 8'h80, 8'h00);
    expect_entry(1'b0, 16'h2000, 8'h80, 8'h10, 16'hFFFE, 16'hABCD, 8'h04, "R5 brk");

    // Return round trip of the break frame
    kick(1'b0, 1'b0, 1'b1, 16'h0, 8'h7D, 8'h04);
    expect_ret(8'h7D, 8'h10, 16'h2000);

    // R7: NMI edge latched while no boundary, with interrupt disable set
    nmi_in = 1'b1; p_in = 8'h04;
    expect_idle(2, "R7 nmi waits for boundary");
    kick(1'b0, 1'b0, 1'b0, 16'h3333, 8'hF0, 8'h04);
    expect_entry(1'b0, 16'h3333, 8'hF0, 8'h04, 16'hFFFA, 16'h1234, 8'h04, "R7 nmi");
    boundary = 1'b1;
    expect_idle(3, "R7 held nmi no retrigger");
    boundary = 1'b0; nmi_in = 1'b0;
    @(negedge clk);

    // R8: latched nmi beats irq and brk
    nmi_in = 1'b1;
    @(negedge clk);
    kick(1'b1, 1'b1, 1'b0, 16'h0102, 8'hC0, 8'h00);
    expect_entry(1'b0, 16'h0102, 8'hC0, 8'h00, 16'hFFFA, 16'h1234, 8'h04, "R8 nmi first");
    nmi_in = 1'b0;

    // R8: irq beats brk (pushed break bit clear)
    kick(1'b1, 1'b1, 1'b1, 16'h0BAD, 8'hB0, 8'h00);
    expect_entry(1'b0, 16'h0BAD, 8'hB0, 8'h00, 16'hFFFE, 16'hABCD, 8'h04, "R8 irq over brk");

    // R3: push wraps the 8-bit stack pointer
    kick(1'b1, 1'b0, 1'b0, 16'h2211, 8'h01, 8'h4B);
    expect_entry(1'b0, 16'h2211, 8'h01, 8'h4B, 16'hFFFE, 16'hABCD, 8'h4F, "R3 push wrap");
    chk(stk[8'h01] == 8'h22 && stk[8'h00] == 8'h11 && stk[8'hFF] == 8'h4B, "R3 wrapped stack bytes",
        {stk[8'h01], stk[8'h00], stk[8'hFF]}, 24'h22114B);

    // R9: pull wraps back
    kick(1'b0, 1'b0, 1'b1, 16'h0, 8'hFE, 8'h04);
    expect_ret(8'hFE, 8'h4B, 16'h2211);

    // R9: every status bit restored from the stack
    stk[8'h41] = 8'hFF; stk[8'h42] = 8'h78; stk[8'h43] = 8'h56;
    kick(1'b0, 1'b0, 1'b1, 16'h0, 8'h40, 8'h00);
    expect_ret(8'h40, 8'hFF, 16'h5678);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule